// File: doc/BRIEF.md
# Prioritized Interrupt Vector Register

This block merges a small set of interrupt sources into one read-only vector. Each source has a pending flag and an enable. Only sources with both set take part. The block reports the winning source as an even code. Software adds that code to its program counter, so each code lands on its own two-byte entry in a jump table. The value 0 means nothing is pending. The code just above the last source is reserved and never appears.

A read strobe from the bus decode samples the vector. On the first cycle of a read, the block pulses a one-cycle clear for the flag it reported. The flag-generating logic drops that flag, and the next read reports the next pending source. The ready/synchronisation source is never cleared by a read, because its flag follows the time-register update handshake. If the strobe is held for several cycles, only one clear is issued and the vector stays frozen at the value first read.

Sources, by index (index 0 has the highest priority): 0 ready/sync, 1 interval event, 2 user alarm, 3 first prescaler tick, 4 second prescaler tick, 5 crystal oscillator fault. The oscillator-fault source is treated like any other, so it can raise a wakeup interrupt.

Top module: `irq_vector_unit`

## Requirements
- R1: With no source both flagged and enabled and no read in progress, `vec_o` is 0 and `flag_clr` is 0.
- R2: Source index i, when it alone is pending, gives `vec_o` = 2*(i+1): 0x2, 0x4, 0x6, 0x8, 0xA, 0xC for indices 0 to 5.
- R3: When several sources are pending, the lowest index wins and only its code is shown.
- R4: `vec_o` is always even and is never the reserved code 0xE.
- R5: A flag whose enable bit is 0 has no effect on `vec_o` or `flag_clr`.
- R6: In the first cycle that `vec_rd` is high, `flag_clr` is one-hot at bit i of the reported source i, except that bit 0 (ready/sync) is never pulsed.
- R7: A read while `vec_o` is 0 pulses no clear.
- R8: While `vec_rd` stays high after its first cycle, `flag_clr` is 0 and `vec_o` holds the value of that first cycle, even if the flags change.
- R9: After a read clears the reported flag, the next read reports the next pending source by priority, ending at 0.
- R10: A read strobe that is high in the first cycle after reset release counts as a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_flag | input | 6 | Pending flag per source, index 0 highest priority |
| irq_en | input | 6 | Enable per source |
| vec_rd | input | 1 | Read strobe for the vector register |
| vec_o | output | 4 | Even-valued vector code, 0 when idle |
| flag_clr | output | 6 | One-cycle clear pulse per source |

## Verification
Most faults show up in the same cycle they occur, because the vector and the clear pulse are combinational outputs of the live requests:
- A broken priority chain shows the wrong code at once.
- A bad code mapping shows a wrong or odd code at once.
- A missing enable gate shows a code when the sources are disabled.

The only state is the read-edge register and the frozen vector. A fault there shows one cycle into a held strobe, as a second clear pulse or a vector that tracks the changed flags. A fault in reset shows as a lost clear when the strobe is already high at reset release. A drain sequence catches a clear on the wrong bit at the following read, because the vector stays on the same code.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   typedef enum logic {RD_IDLE = 1'b0, RD_HELD = 1'b1} rd_state_e;

   function automatic int code_bits_needed(input int n_src);
      return $clog2(2 * (n_src + 1) + 1);
   endfunction
endpackage

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
   parameter int N_SRC = 6
) (
   input  logic [N_SRC-1:0] req,
   output logic [N_SRC-1:0] grant,
   output logic             any_req
);
   logic [N_SRC-1:0] below_any;

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_chain
         if (i == 0) begin : g_first
            assign below_any[i] = 1'b0;
         end else begin : g_rest
            assign below_any[i] = below_any[i-1] | req[i-1];
         end
         assign grant[i] = req[i] & ~below_any[i];
      end
   endgenerate

   assign any_req = |req;
endmodule

// File: rtl/irqv_code_map.sv
module irqv_code_map #(
   parameter int N_SRC = 6,
   parameter int VEC_W = 4
) (
   input  logic [N_SRC-1:0] grant,
   output logic [VEC_W-1:0] code
);
   logic [VEC_W-1:0] term [N_SRC];

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_term
         localparam logic [VEC_W-1:0] SRC_CODE = VEC_W'(2 * (i + 1));
         assign term[i] = grant[i] ? SRC_CODE : '0;
      end
   endgenerate

   always_comb begin
      code = '0;
      for (int i = 0; i < N_SRC; i++) code = code | term[i];
   end
endmodule

// File: rtl/irqv_read_ctl.sv
module irqv_read_ctl
   import irqv_pkg::*;
#(
   parameter int               N_SRC        = 6,
   parameter int               VEC_W        = 4,
   parameter logic [N_SRC-1:0] KEEP_MASK    = 6'b000001,
   parameter bit               HOLD_ON_READ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic [VEC_W-1:0] live_code,
   input  logic [N_SRC-1:0] live_grant,
   output logic [VEC_W-1:0] vec_out,
   output logic [N_SRC-1:0] clr_out
);
   rd_state_e        rd_state;
   logic             rd_first;
   logic [VEC_W-1:0] held_code;

   assign rd_first = rd_stb & (rd_state == RD_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_state <= RD_IDLE;
      else        rd_state <= rd_stb ? RD_HELD : RD_IDLE;
   end

   assign clr_out = rd_first ? (live_grant & ~KEEP_MASK) : '0;

   generate
      if (HOLD_ON_READ) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        held_code <= '0;
            else if (rd_first) held_code <= live_code;
         end
         assign vec_out = (rd_stb && rd_state == RD_HELD) ? held_code : live_code;
      end else begin : g_live
         assign held_code = '0;
         assign vec_out   = live_code;
      end
   endgenerate
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import irqv_pkg::*;
#(
   parameter int               N_SRC        = 6,
   parameter int               VEC_W        = 4,
   parameter logic [N_SRC-1:0] KEEP_MASK    = 6'b000001,
   parameter bit               HOLD_ON_READ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_flag,
   input  logic [N_SRC-1:0] irq_en,
   input  logic             vec_rd,
   output logic [VEC_W-1:0] vec_o,
   output logic [N_SRC-1:0] flag_clr
);
   localparam int MIN_W = code_bits_needed(N_SRC);

   generate
      if (N_SRC < 1) begin : g_bad_n
         $error("irq_vector_unit: N_SRC must be at least 1");
      end
      if (VEC_W < MIN_W) begin : g_bad_w
         $error("irq_vector_unit: VEC_W too narrow for codes and reserved value");
      end
   endgenerate

   logic [N_SRC-1:0] req;
   logic [N_SRC-1:0] grant;
   logic             any_req;
   logic [VEC_W-1:0] live_code;

   assign req = irq_flag & irq_en;

   irqv_prio_pick #(.N_SRC(N_SRC)) u_pick (
      .req     (req),
      .grant   (grant),
      .any_req (any_req)
   );

   irqv_code_map #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_map (
      .grant (grant),
      .code  (live_code)
   );

   irqv_read_ctl #(
      .N_SRC        (N_SRC),
      .VEC_W        (VEC_W),
      .KEEP_MASK    (KEEP_MASK),
      .HOLD_ON_READ (HOLD_ON_READ)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_stb     (vec_rd),
      .live_code  (live_code),
      .live_grant (grant),
      .vec_out    (vec_o),
      .clr_out    (flag_clr)
   );

   logic unused_any;
   assign unused_any = any_req;
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
   parameter int               N_SRC        = 6,
   parameter int               VEC_W        = 4,
   parameter logic [N_SRC-1:0] KEEP_MASK    = 6'b000001,
   parameter bit               HOLD_ON_READ = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] irq_flag,
   input logic [N_SRC-1:0] irq_en,
   input logic             vec_rd,
   input logic [VEC_W-1:0] vec_o,
   input logic [N_SRC-1:0] flag_clr
);
   localparam logic [VEC_W-1:0] RSV_CODE = VEC_W'(2 * (N_SRC + 1));

   assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_rd && (irq_flag & irq_en) == '0) |-> (vec_o == '0 && flag_clr == '0));

   assert_even_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_o[0] == 1'b0 && vec_o != RSV_CODE));

   assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_clr));

   assert_keep_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr & KEEP_MASK) == '0);

   assert_clr_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr != '0) |-> vec_rd);

   assert_clr_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr & ~(irq_flag & irq_en)) == '0);

   assert_no_clr_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr != '0) |-> (vec_o != '0));

   assert_single_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && $past(vec_rd) && $past(rst_n)) |-> (flag_clr == '0));

   generate
      if (HOLD_ON_READ) begin : g_hold_chk
         assert_hold_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_rd && $past(vec_rd) && $past(rst_n)) |-> $stable(vec_o));
      end
   endgenerate
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
   .N_SRC        (N_SRC),
   .VEC_W        (VEC_W),
   .KEEP_MASK    (KEEP_MASK),
   .HOLD_ON_READ (HOLD_ON_READ)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_flag (irq_flag),
   .irq_en   (irq_en),
   .vec_rd   (vec_rd),
   .vec_o    (vec_o),
   .flag_clr (flag_clr)
);

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] flg, en;
   logic       rd;
   logic [3:0] vec;
   logic [5:0] clr;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   irq_vector_unit uut (
      .clk(clk), .rst_n(rst_n), .irq_flag(flg), .irq_en(en),
      .vec_rd(rd), .vec_o(vec), .flag_clr(clr)
   );

   function automatic logic [3:0] exp_vec(input logic [5:0] p);
      for (int i = 0; i < 6; i++) if (p[i]) return 4'(2 * (i + 1));
      return 4'h0;
   endfunction

   function automatic logic [5:0] exp_clr(input logic [5:0] p);
      for (int i = 0; i < 6; i++) if (p[i]) return (i == 0) ? 6'h00 : 6'(1 << i);
      return 6'h00;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic set_in(input logic [5:0] f, input logic [5:0] e, input string req);
      @(negedge clk);
      flg = f; en = e;
      #5;
      chk(req, {4'h0, vec}, {4'h0, exp_vec(f & e)});
      chk(req, {2'b0, clr}, 8'h00);
      chk({req, "_R4"}, {7'h0, vec[0] | (vec == 4'hE)}, 8'h00);
   endtask

   // read lasting 'hold' cycles; flag logic drops cleared bits one edge later
   task automatic do_read(input int hold, input logic [5:0] perturb, input string req);
      logic [3:0] got;
      logic [5:0] c;
      @(negedge clk);
      rd = 1'b1;
      #5;
      chk({req, "_vec"}, {4'h0, vec}, {4'h0, exp_vec(flg & en)});
      chk({req, "_clr"}, {2'b0, clr}, {2'b0, exp_clr(flg & en)});
      got = vec; c = clr;
      for (int k = 1; k < hold; k++) begin
         @(negedge clk);
         if (k == 1) flg = (flg & ~c) | perturb;
         #5;
         chk("R8_clr_held", {2'b0, clr}, 8'h00);
         chk("R8_vec_held", {4'h0, vec}, {4'h0, got});
      end
      @(negedge clk);
      if (hold == 1) flg = flg & ~c;
      rd = 1'b0;
      #5;
      chk({req, "_after"}, {4'h0, vec}, {4'h0, exp_vec(flg & en)});
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R9 act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [5:0] rf, re;
      void'($urandom(32'd2024));
      rst_n = 1'b0; flg = '0; en = '0; rd = 1'b0;
      repeat (3) @(posedge clk);
      #5;
      chk("R1_reset_vec", {4'h0, vec}, 8'h00);
      chk("R1_reset_clr", {2'b0, clr}, 8'h00);
      @(negedge clk); rst_n = 1'b1;

      set_in(6'h00, 6'h3F, "R1_idle");
      for (int i = 0; i < 6; i++) set_in(6'(1 << i), 6'h3F, "R2_single");
      set_in(6'h3F, 6'h00, "R5_all_masked");
      set_in(6'h3F, 6'h3E, "R5_ready_masked");
      set_in(6'h30, 6'h3F, "R3_pair_hi");
      set_in(6'h21, 6'h3F, "R3_pair_ends");
      set_in(6'h2A, 6'h3F, "R3_scatter");

      // drain: 4,6,8,A,C then 0
      set_in(6'h3E, 6'h3F, "R9_setup");
      for (int k = 0; k < 5; k++) do_read(1, 6'h00, "R9_drain");
      chk("R9_empty", {4'h0, vec}, 8'h00);

      set_in(6'h05, 6'h3F, "R6_setup");
      do_read(1, 6'h00, "R6_ready_kept");
      chk("R6_ready_stays", {2'b0, flg}, 8'h05);

      set_in(6'h00, 6'h3F, "R7_setup");
      do_read(1, 6'h00, "R7_empty_read");

      set_in(6'h10, 6'h3F, "R5_setup");
      en = 6'h2F;
      do_read(1, 6'h00, "R5_masked_read");
      chk("R5_flag_left", {2'b0, flg}, 8'h10);

      set_in(6'h28, 6'h3F, "R8_setup");
      do_read(4, 6'h02, "R8_held");

      // strobe already high at reset release
      @(negedge clk); rst_n = 1'b0; rd = 1'b1; flg = 6'h04; en = 6'h3F;
      @(negedge clk); rst_n = 1'b1;
      #5;
      chk("R10_first_after_reset", {2'b0, clr}, 8'h04);
      @(negedge clk); rd = 1'b0; flg = 6'h00;

      for (int n = 0; n < 300; n++) begin
         rf = 6'($urandom); re = 6'($urandom);
         set_in(rf, re, "R3_random");
         if (n % 4 == 0) do_read(1 + ($urandom % 3), 6'($urandom), "R6_random");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule